// File: doc/BRIEF.md
# Clock Frequency and Flash Wait-State Configurator

This block holds two software-visible settings on an APB slave port. One chooses the system clock frequency from a fixed menu of thirteen rates. The other sets how many wait states the flash memory controller inserts. A 4-bit code goes out to an external glitch-free clock switch. A 2-bit code goes out to the flash controller.

The hardware keeps the flash timing safe at all times. Software cannot choose a wait-state count that is too small for the current clock. Such a write is raised to the smallest safe count. When software picks a faster clock, the wait-state setting is raised in the same cycle if the current setting would no longer be safe. A write of a reserved frequency code is replaced by the 50 MHz code. The clock switching circuit itself lies outside this block.

Top module: `clkws_cfg`

## Requirements
- R1: After reset (power-on or system, both on `presetn`), `clkSel` is 0xD (50 MHz) and `waitStates` is 3.
- R2: A write to offset 0x20 stores `pwdata[3:0]` as the clock code when it is a valid code. Valid codes are 0x1 to 0xD, meaning 1, 2, 4, 6, 8, 10, 12, 15, 20, 25, 30, 40 and 50 MHz in that order. Bits 31:4 of the write are ignored.
- R3: A write of a reserved clock code (0x0, 0xE or 0xF) stores 0xD, so `clkSel` never holds a reserved code.
- R4: A write to offset 0x24 takes `pwdata[1:0]` as the wait-state code. The smallest safe code is 0 for codes 0x1 to 0x7, 1 for 0x8 and 0x9, 2 for 0xA, and 3 for 0xB to 0xD. A write below the smallest safe code for the current clock stores that smallest code instead.
- R5: A wait-state write at or above the smallest safe code for the current clock is stored exactly as written.
- R6: A clock write whose new code needs more wait states than are currently set raises `waitStates` to the new smallest safe code, in the same cycle as the clock change.
- R7: A clock write never lowers `waitStates`. With no wait-state write, `waitStates` never decreases.
- R8: A read of offset 0x20 returns the clock code in bits 3:0. A read of offset 0x24 returns the wait-state code in bits 1:0. All other bits, and reads of any other offset, return zero.
- R9: A write changes state only in the APB access phase (`psel`, `penable` and `pwrite` all high). A write to any offset other than 0x20 or 0x24 changes nothing.
- R10: At every cycle outside reset, `waitStates` is at least the smallest safe code for `clkSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset, fed by both power-on and system reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write, high for a write |
| paddr | input | 6 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| clkSel | output | 4 | Frequency code to the clock switch |
| waitStates | output | 2 | Wait-state code to the flash controller |

## Verification
The hardest case is the interaction between the two registers. A clock change must raise the wait states only when the current setting is too low. A lower clock must leave a high setting alone. To test this, the stimulus table first lowers the clock and writes a small wait-state code. It then steps the clock up through each threshold of the safe-code table, so that every automatic raise starts from a known low setting. Reserved clock codes are then written while the wait states are low, which checks that the 50 MHz substitution also forces the wait states to 3.

// File: rtl/clkws_pkg.sv
package clkws_pkg;
  localparam int CLK_W = 4;
  localparam int WS_W  = 2;
  localparam logic [CLK_W-1:0] CLK_DEFAULT = 4'hD;
  localparam logic [WS_W-1:0]  WS_DEFAULT  = 2'd3;

  typedef struct packed {
    logic wrClk;
    logic wrWs;
    logic rdClk;
    logic rdWs;
  } cfgStrobe_t;

  function automatic logic isReserved(input logic [CLK_W-1:0] code);
    return (code == 4'h0) || (code > CLK_DEFAULT);
  endfunction

  function automatic logic [WS_W-1:0] minWait(input logic [CLK_W-1:0] code);
    logic [WS_W-1:0] w;
    if (code <= 4'h7)      w = 2'd0;
    else if (code <= 4'h9) w = 2'd1;
    else if (code == 4'hA) w = 2'd2;
    else                   w = 2'd3;
    return w;
  endfunction
endpackage

// File: rtl/clkws_ctrl.sv
module clkws_ctrl
  import clkws_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CLK_OFF = 'h20,
  parameter int WS_OFF  = 'h24
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output cfgStrobe_t        strb
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CLK_WORD = WORD_W'(CLK_OFF >> 2);
  localparam logic [WORD_W-1:0] WS_WORD  = WORD_W'(WS_OFF >> 2);

  logic [WORD_W-1:0] wordAddr;
  logic wrAccess, rdAccess, hitClk, hitWs;

  always_comb begin
    wordAddr = paddr[ADDR_W-1:2];
    hitClk   = (wordAddr == CLK_WORD);
    hitWs    = (wordAddr == WS_WORD);
    wrAccess = psel && penable && pwrite;
    rdAccess = psel && !pwrite;
    strb.wrClk = wrAccess && hitClk;
    strb.wrWs  = wrAccess && hitWs;
    strb.rdClk = rdAccess && hitClk;
    strb.rdWs  = rdAccess && hitWs;
  end

  // R9: one register at most is written per cycle, and only in the access phase
  assert_one_write_R9: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0({strb.wrClk, strb.wrWs}));
  assert_access_phase_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (strb.wrClk || strb.wrWs) |-> (psel && penable && pwrite));
endmodule

// File: rtl/clkws_datapath.sv
module clkws_datapath
  import clkws_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  cfgStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CLK_W-1:0]  clkQ,
  output logic [WS_W-1:0]   wsQ
);
  logic [CLK_W-1:0] clkReq, clkNext;
  logic [WS_W-1:0]  wsReq, wsFloor, wsNext;

  always_comb begin
    clkReq  = wrData[CLK_W-1:0];
    clkNext = strb.wrClk ? (isReserved(clkReq) ? CLK_DEFAULT : clkReq) : clkQ;
    wsReq   = strb.wrWs ? wrData[WS_W-1:0] : wsQ;
    wsFloor = minWait(clkNext);
    wsNext  = (wsReq < wsFloor) ? wsFloor : wsReq;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      clkQ <= CLK_DEFAULT;
      wsQ  <= WS_DEFAULT;
    end else begin
      clkQ <= clkNext;
      wsQ  <= wsNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdClk) rdData[CLK_W-1:0] = clkQ;
    else if (strb.rdWs) rdData[WS_W-1:0] = wsQ;
  end

  assert_ws_safe_R10: assert property (@(posedge pclk) disable iff (!presetn)
    wsQ >= minWait(clkQ));
  assert_clk_legal_R3: assert property (@(posedge pclk) disable iff (!presetn)
    !isReserved(clkQ));
  // R7: without a wait-state write the setting only moves up
  assert_no_lower_R7: assert property (@(posedge pclk) disable iff (!presetn)
    !strb.wrWs |=> wsQ >= $past(wsQ));
  assert_hold_idle_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (!strb.wrWs && !strb.wrClk) |=> ($stable(clkQ) && $stable(wsQ)));
endmodule

// File: rtl/clkws_cfg.sv
module clkws_cfg
  import clkws_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [CLK_W-1:0]  clkSel,
  output logic [WS_W-1:0]   waitStates
);
  cfgStrobe_t strb;

  clkws_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .strb(strb)
  );

  clkws_datapath #(.DATA_W(DATA_W)) uData (
    .pclk(pclk), .presetn(presetn), .strb(strb), .wrData(pwdata),
    .rdData(prdata), .clkQ(clkSel), .wsQ(waitStates)
  );
endmodule

// File: tb/sim_clkws_cfg.sv
module sim_clkws_cfg;
  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [3:0] clkSel;
  logic [1:0] waitStates;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2 pclk = ~pclk;

  clkws_cfg u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .clkSel(clkSel), .waitStates(waitStates)
  );

  // entry: {isWs, data[31:0], expClk[3:0], expWs[1:0]}
  localparam int NV = 22;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000, 4'hD, 2'd3},  // R4 clamp at 50 MHz
    {1'b0, 32'h0000_0007, 4'h7, 2'd3},  // R2 R7 slower clock keeps ws
    {1'b1, 32'h0000_0000, 4'h7, 2'd0},  // R5
    {1'b0, 32'h0000_0008, 4'h8, 2'd1},  // R6 15 MHz
    {1'b0, 32'h0000_000A, 4'hA, 2'd2},  // R6 25 MHz
    {1'b0, 32'h0000_0001, 4'h1, 2'd2},  // R7
    {1'b1, 32'h0000_0001, 4'h1, 2'd1},  // R5
    {1'b0, 32'h0000_0000, 4'hD, 2'd3},  // R3 R6
    {1'b0, 32'h0000_0003, 4'h3, 2'd3},  // R2
    {1'b1, 32'h0000_0000, 4'h3, 2'd0},  // R5
    {1'b0, 32'h0000_000E, 4'hD, 2'd3},  // R3
    {1'b0, 32'h0000_0009, 4'h9, 2'd3},  // R7
    {1'b1, 32'h0000_0002, 4'h9, 2'd2},  // R5
    {1'b1, 32'h0000_0000, 4'h9, 2'd1},  // R4 clamp at 20 MHz
    {1'b0, 32'h0000_0004, 4'h4, 2'd1},  // R7
    {1'b1, 32'h0000_0000, 4'h4, 2'd0},  // R5
    {1'b0, 32'h0000_000F, 4'hD, 2'd3},  // R3 R6
    {1'b0, 32'h0000_0006, 4'h6, 2'd3},
    {1'b1, 32'hFFFF_FFF2, 4'h6, 2'd2},  // R4 upper bits ignored
    {1'b0, 32'hFFFF_FFF5, 4'h5, 2'd2},  // R2 upper bits ignored
    {1'b1, 32'h0000_0000, 4'h5, 2'd0},
    {1'b0, 32'h0000_000B, 4'hB, 2'd3}   // R6 30 MHz
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge pclk);
    check("R1 clk", 32'(clkSel), 32'hD);
    check("R1 ws", 32'(waitStates), 32'd3);
    presetn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apbWrite(VEC[i][38] ? 6'h24 : 6'h20, VEC[i][37:6]);
      check($sformatf("R2-vec%0d clk", i), 32'(clkSel), 32'(VEC[i][5:2]));
      check($sformatf("R4-vec%0d ws", i), 32'(waitStates), 32'(VEC[i][1:0]));
    end

    // R8 readback
    apbRead(6'h20, rd); check("R8 clk read", rd, 32'hB);
    apbRead(6'h24, rd); check("R8 ws read", rd, 32'h3);
    apbRead(6'h28, rd); check("R8 other read", rd, 32'h0);

    // R9 other offset and setup-only phase
    apbWrite(6'h20, 32'h1);
    apbWrite(6'h24, 32'h0);
    apbWrite(6'h28, 32'h0000_000D);
    check("R9 other offset clk", 32'(clkSel), 32'h1);
    check("R9 other offset ws", 32'(waitStates), 32'h0);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 6'h20; pwdata = 32'hD; penable = 1'b0;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    check("R9 setup only", 32'(clkSel), 32'h1);

    // R1 system reset mid-run
    presetn = 1'b0;
    @(negedge pclk);
    check("R1 rereset clk", 32'(clkSel), 32'hD);
    check("R1 rereset ws", 32'(waitStates), 32'd3);
    presetn = 1'b1;
    apbRead(6'h24, rd); check("R8 ws after reset", rd, 32'h3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule